// File: doc/BRIEF.md
# NCO-timed UART serial engine

This block is the serial core of a UART. It turns bytes offered on a ready/valid input into asynchronous serial frames on `txd`, and it turns frames arriving on `rxd` into bytes delivered with a one-cycle valid pulse. Frame errors, parity errors and break conditions are reported as single-cycle error pulses. Register decoding and byte buffering sit outside the block, and the enables, parity selection, loopback modes and rate word come in as plain inputs.

Bit timing comes from a phase accumulator rather than an integer divider. On every clock, a 16-bit step word is added to an accumulator of the same width. Each carry out is one oversampling tick, and one bit lasts 16 ticks. The serial rate is therefore step × f_clk / 2^20, which gives fine rate resolution without a fractional divider.

Two loopback modes help with bring-up. System loopback feeds the transmitter's serial stream into the receiver, holds the `txd` pin high and ignores `rxd`. Line loopback connects `rxd` straight to `txd` while the receiver keeps working.

Top module: `nco_uart`

## Requirements
- R1: Each clock adds `nco_step` to a 16-bit accumulator, and each carry is one tick. A serial bit lasts 16 ticks, so with `nco_step` = 4096 a bit is 256 clocks long, and with 8192 it is 128 clocks long.
- R2: `txd` idles at 1. Each frame is one 0 start bit, then 8 data bits least significant first, then an optional parity bit, then exactly one stop bit at 1.
- R3: When `parity_en` = 1, a parity bit follows the data. With `parity_odd` = 0 it makes the count of ones in data plus parity even. With `parity_odd` = 1 it makes that count odd.
- R4: `tx_ready` is 1 only while `tx_en` = 1 and no frame is being sent. A byte is taken in a cycle where `tx_valid` and `tx_ready` are both 1.
- R5: The receiver votes on the 7th, 8th and 9th ticks of each bit. A start bit that votes 1 is discarded. When the stop bit votes 1, `rx_valid` pulses for one cycle with the byte on `rx_data`.
- R6: When `parity_en` = 1 and the received parity does not match the selected scheme, `rx_parity_err` pulses in the same cycle as `rx_valid`.
- R7: When the stop bit votes 0, `rx_frame_err` pulses and `rx_valid` stays 0.
- R8: When the stop bit votes 0 and all 8 data bits are 0, `rx_break_err` pulses together with `rx_frame_err`.
- R9: While `rx_en` = 0, no frame is received and none of `rx_valid`, `rx_frame_err`, `rx_parity_err` or `rx_break_err` pulses.
- R10: While `sys_loop` = 1 (and `line_loop` = 0), transmitted frames are received by this block, `txd` stays 1, and frames on `rxd` are ignored.
- R11: While `line_loop` = 1, `txd` follows `rxd`, and incoming frames are still received.
- R12: While `nf_en` = 1, the receive line changes level only after three equal consecutive synchronised samples. A line that toggles every clock produces no receive event.
- R13: Transmit and receive run independently, so a frame can be sent while another is being received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nco_step | input | 16 | Phase step added each clock |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | Receive enable |
| nf_en | input | 1 | Receive noise filter enable |
| parity_en | input | 1 | Adds and checks a parity bit |
| parity_odd | input | 1 | 1 = odd parity, 0 = even parity |
| sys_loop | input | 1 | Internal loop from transmitter to receiver |
| line_loop | input | 1 | Echo of `rxd` onto `txd` |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | `tx_data` is offered |
| tx_ready | output | 1 | Transmitter can take a byte |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle pulse: good frame received |
| rx_frame_err | output | 1 | One-cycle pulse: stop bit was 0 |
| rx_parity_err | output | 1 | One-cycle pulse: parity mismatch |
| rx_break_err | output | 1 | One-cycle pulse: all-zero frame with stop bit 0 |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input |

## Verification
A transmit handshake, or the shifting of a transmit bit, can land in the same cycle as a receive vote or the delivery of a received byte. The two paths share only the tick, so a fault in the shared timing or the state could corrupt both. To provoke this, the bench offers a byte to the transmitter while it drives a different frame into `rxd` at the same rate. The two frames overlap for their whole length. The bench then judges the result at both ends. A serial decoder on `txd` must recover the sent byte. The receive scoreboard must see exactly one clean delivery of the driven byte.

// File: rtl/nco_uart.sv
`timescale 1ns/1ps
module nco_uart #(
  parameter int NCO_W  = 16,
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCO_W-1:0]  nco_step,
  input  logic              tx_en,
  input  logic              rx_en,
  input  logic              nf_en,
  input  logic              parity_en,
  input  logic              parity_odd,
  input  logic              sys_loop,
  input  logic              line_loop,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              rx_frame_err,
  output logic              rx_parity_err,
  output logic              rx_break_err,
  output logic              txd,
  input  logic              rxd
);
  localparam int SUB_W = $clog2(OVS);
  localparam int FRM_W = DATA_W + 3;
  localparam int IDX_W = $clog2(FRM_W + 1);
  localparam logic [SUB_W-1:0] SUB_V0   = SUB_W'(OVS/2 - 2);
  localparam logic [SUB_W-1:0] SUB_V1   = SUB_W'(OVS/2 - 1);
  localparam logic [SUB_W-1:0] SUB_DEC  = SUB_W'(OVS/2);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVS - 1);
  localparam logic [IDX_W-1:0] IDX_DATA = IDX_W'(DATA_W);
  localparam logic [IDX_W-1:0] LEN_PAR  = IDX_W'(FRM_W);
  localparam logic [IDX_W-1:0] LEN_NOP  = IDX_W'(FRM_W - 1);

  // rate tick
  logic [NCO_W-1:0] acc;
  logic             tick;
  logic [NCO_W:0]   acc_sum;
  assign acc_sum = {1'b0, acc} + {1'b0, nco_step};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      acc  <= '0;
      tick <= 1'b0;
    end else begin
      acc  <= acc_sum[NCO_W-1:0];
      tick <= acc_sum[NCO_W];
    end

  // transmitter
  logic [FRM_W-1:0] tx_sh;
  logic [IDX_W-1:0] tx_left;
  logic [SUB_W-1:0] tx_sub;
  logic             tx_busy, tx_bit;

  assign tx_busy  = tx_left != '0;
  assign tx_ready = tx_en && !tx_busy;
  assign tx_bit   = tx_busy ? tx_sh[0] : 1'b1;
  assign txd      = line_loop ? rxd : (sys_loop ? 1'b1 : tx_bit);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_sh   <= '1;
      tx_left <= '0;
      tx_sub  <= '0;
    end else if (tx_valid && tx_ready) begin
      tx_sh   <= parity_en ? {1'b1, (^tx_data) ^ parity_odd, tx_data, 1'b0}
                           : {2'b11, tx_data, 1'b0};
      tx_left <= parity_en ? LEN_PAR : LEN_NOP;
      tx_sub  <= '0;
    end else if (tick && tx_busy) begin
      tx_sub <= tx_sub + 1'b1;
      if (tx_sub == SUB_LAST) begin
        tx_sh   <= {1'b1, tx_sh[FRM_W-1:1]};
        tx_left <= tx_left - 1'b1;
      end
    end

  // receive line: source select, synchroniser, filter
  logic       rx_src, rx_flt, rx_bit;
  logic [3:0] rs;
  assign rx_src = sys_loop ? tx_bit : rxd;
  assign rx_bit = nf_en ? rx_flt : rs[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rs     <= '1;
      rx_flt <= 1'b1;
    end else begin
      rs <= {rs[2:0], rx_src};
      if (rs[3:1] == 3'b111)      rx_flt <= 1'b1;
      else if (rs[3:1] == 3'b000) rx_flt <= 1'b0;
    end

  // receiver
  logic              rx_busy, rx_par, maj;
  logic [SUB_W-1:0]  rx_sub;
  logic [IDX_W-1:0]  rx_idx, rx_last;
  logic [1:0]        vote;
  logic [DATA_W-1:0] rx_sh;

  assign maj     = (vote[0] & vote[1]) | (vote[0] & rx_bit) | (vote[1] & rx_bit);
  assign rx_last = parity_en ? IDX_W'(DATA_W + 2) : IDX_W'(DATA_W + 1);
  assign rx_data = rx_sh;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_busy <= 1'b0;  rx_sub <= '0;  rx_idx <= '0;  vote <= '0;
      rx_sh   <= '0;    rx_par <= 1'b0;
      rx_valid <= 1'b0; rx_frame_err <= 1'b0;
      rx_parity_err <= 1'b0; rx_break_err <= 1'b0;
    end else begin
      rx_valid <= 1'b0; rx_frame_err <= 1'b0;
      rx_parity_err <= 1'b0; rx_break_err <= 1'b0;
      if (!rx_en) rx_busy <= 1'b0;
      else if (tick) begin
        if (!rx_busy) begin
          if (!rx_bit) begin
            rx_busy <= 1'b1;
            rx_sub  <= SUB_W'(1);
            rx_idx  <= '0;
          end
        end else begin
          rx_sub <= rx_sub + 1'b1;
          if (rx_sub == SUB_V0) vote[0] <= rx_bit;
          if (rx_sub == SUB_V1) vote[1] <= rx_bit;
          if (rx_sub == SUB_DEC) begin
            if (rx_idx == '0) begin
              if (maj) rx_busy <= 1'b0;
            end else if (rx_idx <= IDX_DATA) begin
              rx_sh <= {maj, rx_sh[DATA_W-1:1]};
            end else if (rx_idx != rx_last) begin
              rx_par <= maj;
            end else begin
              rx_busy <= 1'b0;
              if (maj) begin
                rx_valid      <= 1'b1;
                rx_parity_err <= parity_en && (rx_par != ((^rx_sh) ^ parity_odd));
              end else begin
                rx_frame_err <= 1'b1;
                rx_break_err <= rx_sh == '0;
              end
            end
          end
          if (rx_sub == SUB_LAST) rx_idx <= rx_idx + 1'b1;
        end
      end
    end
endmodule

// File: rtl/nco_uart_chk.sv
`timescale 1ns/1ps
module nco_uart_chk (
  input logic clk,
  input logic rst_n,
  input logic rx_en,
  input logic sys_loop,
  input logic line_loop,
  input logic tx_valid,
  input logic tx_ready,
  input logic txd,
  input logic rx_valid,
  input logic rx_frame_err,
  input logic rx_parity_err,
  input logic rx_break_err
);
  a_r2_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready && !sys_loop && !line_loop) |-> txd);
  a_r4_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);
  a_r6_parity_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    rx_parity_err |-> rx_valid);
  a_r7_no_valid_on_frame_err: assert property (@(posedge clk) disable iff (!rst_n)
    rx_frame_err |-> !rx_valid);
  a_r8_break_is_frame_err: assert property (@(posedge clk) disable iff (!rst_n)
    rx_break_err |-> rx_frame_err);
  a_r9_rx_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !(rx_valid || rx_frame_err || rx_break_err));
  a_r10_sysloop_pin_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_loop && !line_loop) |-> txd);
endmodule

bind nco_uart nco_uart_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .sys_loop(sys_loop),
  .line_loop(line_loop), .tx_valid(tx_valid), .tx_ready(tx_ready), .txd(txd),
  .rx_valid(rx_valid), .rx_frame_err(rx_frame_err),
  .rx_parity_err(rx_parity_err), .rx_break_err(rx_break_err)
);

// File: tb/nco_uart_bench.sv
`timescale 1ns/1ps
module nco_uart_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] nco_step = 16'd4096;
  logic tx_en = 0, rx_en = 0, nf_en = 0, parity_en = 0, parity_odd = 0;
  logic sys_loop = 0, line_loop = 0, tx_valid = 0, rxd = 1'b1;
  logic [7:0] tx_data = '0;
  logic tx_ready, rx_valid, rx_frame_err, rx_parity_err, rx_break_err, txd;
  logic [7:0] rx_data;

  nco_uart u_nco_uart (
    .clk(clk), .rst_n(rst_n), .nco_step(nco_step), .tx_en(tx_en), .rx_en(rx_en),
    .nf_en(nf_en), .parity_en(parity_en), .parity_odd(parity_odd),
    .sys_loop(sys_loop), .line_loop(line_loop), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_data(rx_data),
    .rx_valid(rx_valid), .rx_frame_err(rx_frame_err),
    .rx_parity_err(rx_parity_err), .rx_break_err(rx_break_err),
    .txd(txd), .rxd(rxd)
  );

  always #4 clk = ~clk;

  int checks = 0, errors = 0, evts = 0, bp = 256;
  bit tx_mon_on = 1'b1, done = 1'b0;
  logic [11:0] exp_rx[$];
  string       exp_rx_tag[$];
  logic [7:0]  exp_tx[$];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_sim();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // receive scoreboard monitor: {valid, perr, ferr, berr, data}
  always @(negedge clk)
    if (rst_n && (rx_valid || rx_frame_err || rx_parity_err || rx_break_err)) begin
      logic [11:0] got;
      got = {rx_valid, rx_parity_err, rx_frame_err, rx_break_err, rx_data};
      evts++;
      if (exp_rx.size() == 0) chk(1'b0, "R5 unexpected receive event", got, 0);
      else begin
        logic [11:0] e;
        string t;
        e = exp_rx.pop_front();
        t = exp_rx_tag.pop_front();
        chk(got == e, t, got, e);
      end
    end

  // transmit monitor: independent serial decoder on txd
  initial forever begin
    @(negedge txd);
    if (tx_mon_on && rst_n) begin
      logic [10:0] got, e;
      logic [7:0]  b;
      int n;
      got = '1;
      n = parity_en ? 11 : 10;
      repeat (bp/2) @(negedge clk);
      for (int i = 0; i < n; i++) begin
        got[i] = txd;
        if (i != n-1) repeat (bp) @(negedge clk);
      end
      if (exp_tx.size() == 0) chk(1'b0, "R2 unexpected tx frame", got, 0);
      else begin
        b = exp_tx.pop_front();
        e = parity_en ? {1'b1, (^b) ^ parity_odd, b, 1'b0} : {2'b11, b, 1'b0};
        chk(got == e, parity_en ? "R3 tx parity frame" : "R2 tx frame", got, e);
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_sim();
  end

  task automatic send_tx(input logic [7:0] b);
    if (sys_loop) begin
      exp_rx.push_back({4'b1000, b});
      exp_rx_tag.push_back("R10 system loopback byte");
    end else exp_tx.push_back(b);
    @(negedge clk);
    tx_data  = b;
    tx_valid = 1'b1;
    forever begin
      if (tx_ready) begin
        @(negedge clk);
        tx_valid = 1'b0;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic send_rx(input logic [7:0] b, input bit bad_par, input bit stop,
                         input bit expect_evt, input string tag);
    logic [10:0] fr;
    logic par;
    int n;
    par = (^b) ^ parity_odd ^ bad_par;
    n = parity_en ? 11 : 10;
    fr = parity_en ? {stop, par, b, 1'b0} : {1'b1, stop, b, 1'b0};
    if (expect_evt) begin
      exp_rx.push_back(stop ? {1'b1, parity_en & bad_par, 2'b00, b}
                            : {3'b001, b == 8'h00, b});
      exp_rx_tag.push_back(tag);
    end
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rxd = fr[i];
      repeat (bp/2) @(negedge clk);
      if (line_loop) chk(txd == rxd, "R11 txd follows rxd", txd, rxd);
      if (sys_loop && !line_loop) chk(txd == 1'b1, "R10 txd held high", txd, 1);
      repeat (bp - bp/2 - 1) @(negedge clk);
    end
    @(negedge clk);
    rxd = 1'b1;
    repeat (bp) @(negedge clk);
  endtask

  task automatic settle(input int nbits);
    repeat (nbits * bp) @(negedge clk);
  endtask

  task automatic measure_start(input string tag);
    int w = 0;
    send_tx(8'hFF);
    while (!txd) begin
      @(negedge clk);
      w++;
    end
    chk(w >= bp - bp/16 - 1 && w <= bp + 1, tag, w, bp);
  endtask

  initial begin
    int e0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(txd == 1'b1, "R2 reset idle high", txd, 1);
    chk(tx_ready == 1'b0, "R4 not ready while disabled", tx_ready, 0);
    chk(rx_valid == 1'b0, "R5 no valid after reset", rx_valid, 0);
    tx_en = 1'b1;
    @(negedge clk);
    chk(tx_ready == 1'b1, "R4 ready when enabled and idle", tx_ready, 1);

    measure_start("R1 bit width step 4096");
    settle(11);
    send_tx(8'h35);
    send_tx(8'hA0);
    settle(12);

    parity_en = 1'b1; parity_odd = 1'b0;
    send_tx(8'h07);
    settle(12);
    parity_odd = 1'b1;
    send_tx(8'h07);
    send_tx(8'h00);
    settle(13);
    parity_en = 1'b0; parity_odd = 1'b0;

    nco_step = 16'd8192; bp = 128;
    measure_start("R1 bit width step 8192");
    settle(11);
    nco_step = 16'd4096; bp = 256;
    settle(2);

    rx_en = 1'b1;
    send_rx(8'h96, 0, 1, 1, "R5 receive 0x96");
    send_rx(8'h01, 0, 1, 1, "R5 receive 0x01");

    parity_en = 1'b1;
    send_rx(8'h3C, 0, 1, 1, "R6 even parity good");
    send_rx(8'h3C, 1, 1, 1, "R6 even parity bad");
    parity_odd = 1'b1;
    send_rx(8'h3C, 0, 1, 1, "R6 odd parity good");
    send_rx(8'h5A, 1, 1, 1, "R6 odd parity bad");
    parity_en = 1'b0; parity_odd = 1'b0;

    send_rx(8'h81, 0, 0, 1, "R7 frame error");
    send_rx(8'h00, 0, 0, 1, "R8 break");
    settle(2);

    rx_en = 1'b0;
    e0 = evts;
    send_rx(8'h55, 0, 1, 0, "");
    settle(2);
    chk(evts == e0, "R9 receive disabled", evts - e0, 0);
    rx_en = 1'b1;

    sys_loop = 1'b1;
    send_tx(8'h6B);
    send_tx(8'h90);
    settle(12);
    e0 = evts;
    send_rx(8'h11, 0, 1, 0, "");
    settle(2);
    chk(evts == e0, "R10 rxd ignored in system loopback", evts - e0, 0);
    sys_loop = 1'b0;
    settle(2);

    tx_mon_on = 1'b0;
    line_loop = 1'b1;
    send_rx(8'hE4, 0, 1, 1, "R11 receive during line loopback");
    line_loop = 1'b0;
    settle(1);
    tx_mon_on = 1'b1;

    nf_en = 1'b1;
    e0 = evts;
    for (int i = 0; i < 20 * bp; i++) begin
      @(negedge clk);
      rxd = ~rxd;
    end
    @(negedge clk);
    rxd = 1'b1;
    settle(3);
    chk(evts == e0, "R12 toggling line filtered", evts - e0, 0);
    send_rx(8'h5D, 0, 1, 1, "R12 receive with filter on");
    nf_en = 1'b0;

    fork
      send_tx(8'hC6);
      send_rx(8'h2B, 0, 1, 1, "R13 receive while transmitting");
    join
    settle(4);

    chk(exp_rx.size() == 0, "R5 receive scoreboard drained", exp_rx.size(), 0);
    chk(exp_tx.size() == 0, "R13 transmit scoreboard drained", exp_tx.size(), 0);
    finish_sim();
  end
endmodule